// File: doc/BRIEF.md
# Sampling Phase Spacing Histogram

This block estimates how evenly a group of interleaved sampling clock phases is spread across one system cycle. Every system cycle it receives one word holding the outputs of `NUM_PHASES` samplers that all looked at the same random, asynchronous signal. The word is already resynchronised into the system clock domain. Bit `k` of the word is the sample taken by phase `k`. The time between two neighbouring phases forms a sampling bin. An edge of the input signal is seen in that bin whenever the two samples that bound it disagree, and each bin counts such events in its own counter.

A start pulse clears all counts and opens a measurement window whose length is a programmed number of system cycles. When the window closes, the counts freeze and a done flag rises. Software or a calibration engine then reads the counts one bin at a time through an indexed read port. If the phases are evenly spaced, every bin collects about the same number of edges. A bin whose count sits above or below the mean is wider or narrower than nominal, by an amount proportional to that deviation. Long windows average out jitter, so the window length register is wide.

Top module: `phaseBinHist`

## Requirements
- R1: After reset, `done`, `busy` and `overflow` are low, and every bin reads zero.
- R2: For bin `k` with 1 <= k < NUM_PHASES, the count rises by one in each counting cycle in which `samples[k-1]` differs from `samples[k]`.
- R3: Bin 0 is the wrap bin. Its count rises by one in each counting cycle in which the current `samples[0]` differs from `samples[NUM_PHASES-1]` of the previous cycle. The previous-cycle bit is kept even while no window is open.
- R4: The clock edge that sees `startPulse` high clears all bins, the cycle counter, `done` and `overflow`, and latches `windowLen`. If `windowLen` is nonzero, `busy` is high from the next cycle.
- R5: A window of length L counts exactly the sample words present at the L clock edges that follow the start edge. `done` rises and `busy` falls together, right after the L-th of those edges.
- R6: Once `done` is high, sample words have no effect on any bin until the next start pulse.
- R7: A start with `windowLen` = 0 sets `done` after the start edge, leaves `busy` low and counts nothing.
- R8: A bin that holds its maximum value (2^CNT_W - 1) stays there when more edges arrive, instead of wrapping.
- R9: `overflow` goes high when an edge arrives for a bin that already holds its maximum value. It stays high until the next start pulse.
- R10: `rdData` shows the count of bin `rdIdx` one cycle after the index is presented. An index of NUM_PHASES or above reads zero.
- R11: A read issued while `busy` is high returns the live count from the edge at which the read is sampled, before that edge's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Clears counts and opens a measurement window |
| windowLen | input | WIN_W | Window length in system cycles, latched at start |
| samples | input | NUM_PHASES | One sampler output per phase, already synchronised |
| rdIdx | input | IDX_W | Bin to read |
| rdData | output | CNT_W | Registered count of the selected bin |
| done | output | 1 | Window complete, counts frozen |
| busy | output | 1 | Window open, counting |
| overflow | output | 1 | Sticky flag: a bin reached saturation and received another edge |

## Verification
An incorrect edge vector or a wrong bin-0 pairing corrupts the counts themselves. Such an error shows up only when the bins are read, and the bench computes the exact expected count for every bin over fixed sample sequences. An off-by-one in the cycle counter moves `done` by one cycle and changes every bin by up to one count, so the bench checks the edge at which `done` rises, as well as the cycle just before it. A saturation or freeze fault stays hidden until a long window or post-window activity drives a counter past its limit. The bench causes both and then reads the bins back.

// File: rtl/phase_hist_pkg.sv
package phase_hist_pkg;

  // Strobes from the window control to the bin datapath
  typedef struct packed {
    logic clearAll;   // wipe bins and overflow flag
    logic countEn;    // this cycle's edges are accumulated
  } histStrobe_t;

endpackage

// File: rtl/phaseHistCtrl.sv
module phaseHistCtrl
  import phase_hist_pkg::*;
#(
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [WIN_W-1:0] windowLen,
  output histStrobe_t      strobe,
  output logic             busy,
  output logic             done
);

  logic [WIN_W-1:0] limitReg;
  logic [WIN_W-1:0] cycCnt;
  logic [WIN_W-1:0] cycNext;
  logic             running;
  logic             lastCycle;

  assign cycNext   = cycCnt + 1'b1;
  assign lastCycle = (cycNext == limitReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg <= '0;
      cycCnt   <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
    end else if (startPulse) begin
      limitReg <= windowLen;
      cycCnt   <= '0;
      running  <= (windowLen != '0);
      done     <= (windowLen == '0);
    end else if (running) begin
      cycCnt <= cycNext;
      if (lastCycle) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clearAll = startPulse;
    strobe.countEn  = running && !startPulse;
  end

  assign busy = running;

endmodule

// File: rtl/phaseHistDatapath.sv
module phaseHistDatapath
  import phase_hist_pkg::*;
#(
  parameter int NUM_PHASES = 6,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  histStrobe_t           strobe,
  input  logic [NUM_PHASES-1:0] samples,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [CNT_W-1:0]      rdData,
  output logic                  overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                               prevLast;
  logic [NUM_PHASES-1:0]              edgeVec;
  logic [NUM_PHASES-1:0]              satHit;
  logic [NUM_PHASES-1:0][CNT_W-1:0]   binCnt;
  logic [CNT_W-1:0]                   rdSel;

  // last phase of the previous word closes the wrap bin
  always_ff @(posedge clk) begin
    if (!rstN) prevLast <= 1'b0;
    else       prevLast <= samples[NUM_PHASES-1];
  end

  assign edgeVec[0] = prevLast ^ samples[0];

  for (genvar k = 1; k < NUM_PHASES; k++) begin : g_edge
    assign edgeVec[k] = samples[k-1] ^ samples[k];
  end

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_bin
    logic atMax;
    logic bump;
    assign atMax     = (binCnt[k] == CNT_MAX);
    assign bump      = strobe.countEn && edgeVec[k];
    assign satHit[k] = bump && atMax;

    always_ff @(posedge clk) begin
      if (!rstN)                binCnt[k] <= '0;
      else if (strobe.clearAll) binCnt[k] <= '0;
      else if (bump && !atMax)  binCnt[k] <= binCnt[k] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                overflow <= 1'b0;
    else if (strobe.clearAll) overflow <= 1'b0;
    else if (|satHit)         overflow <= 1'b1;
  end

  always_comb begin
    rdSel = '0;
    for (int k = 0; k < NUM_PHASES; k++) begin
      if (rdIdx == IDX_W'(k)) rdSel = binCnt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdSel;
  end

endmodule

// File: rtl/phaseBinHist.sv
module phaseBinHist
  import phase_hist_pkg::*;
#(
  parameter int NUM_PHASES = 6,
  parameter int CNT_W      = 16,
  parameter int WIN_W      = 32,
  parameter int IDX_W      = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [WIN_W-1:0]      windowLen,
  input  logic [NUM_PHASES-1:0] samples,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [CNT_W-1:0]      rdData,
  output logic                  done,
  output logic                  busy,
  output logic                  overflow
);

  histStrobe_t strobe;

  phaseHistCtrl #(
    .WIN_W (WIN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .windowLen  (windowLen),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  phaseHistDatapath #(
    .NUM_PHASES (NUM_PHASES),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .samples  (samples),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .overflow (overflow)
  );

endmodule

// File: rtl/phaseHistChecker.sv
module phaseHistChecker #(
  parameter int NUM_PHASES = 6,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [IDX_W-1:0] rdIdx,
  input logic [CNT_W-1:0] rdData,
  input logic             done,
  input logic             busy,
  input logic             overflow
);

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (busy ^ done)); // R4

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R5

  AST_FROZEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done) && !startPulse && !$past(startPulse) && $stable(rdIdx))
    |=> $stable(rdData)); // R6

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !startPulse) |=> overflow); // R9

  AST_RANGE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdIdx) >= NUM_PHASES) |=> (rdData == '0)); // R10

endmodule

bind phaseBinHist phaseHistChecker #(
  .NUM_PHASES (NUM_PHASES),
  .CNT_W      (CNT_W),
  .IDX_W      (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .rdIdx      (rdIdx),
  .rdData     (rdData),
  .done       (done),
  .busy       (busy),
  .overflow   (overflow)
);

// File: tb/test_phaseBinHist.sv
module test_phaseBinHist;

  localparam int N    = 6;
  localparam int CW   = 6;
  localparam int WW   = 16;
  localparam int IW   = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          startPulse;
  logic [WW-1:0] windowLen;
  logic [N-1:0]  samples;
  logic [IW-1:0] rdIdx;
  logic [CW-1:0] rdData;
  logic          done, busy, overflow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phaseBinHist #(
    .NUM_PHASES (N),
    .CNT_W      (CW),
    .WIN_W      (WW),
    .IDX_W      (IW)
  ) i_phaseBinHist (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .windowLen  (windowLen),
    .samples    (samples),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .done       (done),
    .busy       (busy),
    .overflow   (overflow)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pat(int mode, int i);
    case (mode)
      0:       return (i % 2 == 1) ? '1 : '0;
      1:       return N'((i * i * 7 + i * 13 + 5) ^ (i >> 2));
      default: return N'(21);
    endcase
  endfunction

  task automatic readBin(int idx, output longint val);
    @(negedge clk);
    rdIdx = IW'(idx);
    @(posedge clk);
    #1 val = rdData;
  endtask

  task automatic testReset();
    longint v;
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 overflow", overflow, 0);
    for (int k = 0; k < N; k++) begin
      readBin(k, v);
      check("R1 bin", v, 0);
    end
  endtask

  // start a window, drive len words, check timing, then read every bin
  task automatic acquire(int len, int mode, string tag);
    int           expB [N];
    bit           expO;
    logic [N-1:0] prevW;
    logic [N-1:0] w;
    longint       v;
    expO = 0;
    for (int k = 0; k < N; k++) expB[k] = 0;
    @(negedge clk);
    windowLen  = WW'(len);
    prevW      = pat(mode, 0);
    samples    = prevW;
    startPulse = 1'b1;
    @(posedge clk);
    #1 startPulse = 1'b0;
    check("R4 overflow cleared", overflow, 0);
    check("R4 busy after start", busy, (len != 0) ? 1 : 0);
    check("R7 done after start", done, (len == 0) ? 1 : 0);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      w = pat(mode, i);
      samples = w;
      for (int k = 0; k < N; k++) begin
        bit h;
        h = (k == 0) ? (prevW[N-1] ^ w[0]) : (w[k-1] ^ w[k]);
        if (h) begin
          if (expB[k] == MAXC) expO = 1;
          else expB[k]++;
        end
      end
      prevW = w;
      if (i == len) check("R5 done before last edge", done, 0);
    end
    @(posedge clk);
    #1;
    check("R5 done after window", done, 1);
    check("R5 busy after window", busy, 0);
    // activity after the window must be ignored (R6)
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      samples = ~samples ^ N'(j);
    end
    for (int k = 0; k < N; k++) begin
      readBin(k, v);
      if (tag != "") check(tag, v, expB[k]);
      else if (k == 0) check("R3 wrap bin", v, expB[k]);
      else check("R2 inner bin", v, expB[k]);
    end
    check("R9 overflow flag", overflow, expO ? 1 : 0);
  endtask

  task automatic testFreeze();
    longint v;
    acquire(10, 0, "");
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      samples = N'(j * 11);
    end
    readBin(0, v);
    check("R6 frozen wrap bin", v, 10);
    readBin(3, v);
    check("R6 frozen inner bin", v, 0);
  endtask

  task automatic testLiveRead();
    longint v;
    @(negedge clk);
    samples    = N'(21);
    windowLen  = WW'(20);
    startPulse = 1'b1;
    @(posedge clk);
    #1 startPulse = 1'b0;
    rdIdx = IW'(2);
    repeat (5) @(posedge clk);
    #1;
    check("R11 live value", rdData, 4);
    check("R11 busy while live", busy, 1);
    repeat (15) @(posedge clk);
    #1;
    check("R5 done at window end", done, 1);
    readBin(2, v);
    check("R11 final value", v, 20);
  endtask

  task automatic testRange();
    longint v;
    readBin(0, v);
    check("R10 valid index", v, 3);
    readBin(6, v);
    check("R10 index six", v, 0);
    readBin(7, v);
    check("R10 index seven", v, 0);
  endtask

  initial begin
    rstN       = 1'b0;
    startPulse = 1'b0;
    windowLen  = '0;
    samples    = '0;
    rdIdx      = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFreeze();
    acquire(25, 1, "");
    acquire(0, 2, "R7 no counts");
    acquire(80, 2, "R8 saturated bin");
    acquire(3, 0, "R4 restart counts");
    testRange();
    testLiveRead();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule